// File: doc/BRIEF.md
# Privilege Trap-Return Status Unit

This unit keeps the hart's current privilege mode and its 64-bit machine status word, and carries out the three trap-return operations and the environment-call operation. The decode stage raises one strobe per cycle. The unit checks the strobe against the current mode. It then produces a redirect target, an illegal-instruction flag or an environment-call exception with its cause. On the next clock edge it commits the new mode and the new status fields together.

The privilege mode is the state machine. Its states are USR (2'b00), SUP (2'b01) and MCH (2'b11), and MCH is the reset state. The machine return goes from MCH to the mode held in the saved machine previous-privilege field, and the value 2'b10 in that field leads to USR. The supervisor return goes from SUP or MCH to SUP when the saved supervisor previous-privilege bit is 1, and to USR when it is 0. The user return and the environment call go back to the same state. An illegal return and an idle cycle also stay in the same state. The status word has a whole-word load port, which the core's CSR write path uses.

Top module: `priv_ret_unit`

## Requirements
- R1: After reset, priv_mode is 2'b11, status is all zeros, and npc_vld, illegal and ecall_exc are low.
- R2: op_onehot bit 0 selects the user return, bit 1 the supervisor return, bit 2 the machine return and bit 3 the environment call, and at most one bit is set. When all bits are zero and st_wr_en is low, npc_vld, illegal and ecall_exc are low and priv_mode and status hold.
- R3: A machine return in machine mode copies status bit 7 into bit 3 and sets bit 7. It loads priv_mode from bits 12:11, where 2'b10 is read as user. It clears bits 12:11 and drives npc = mepc with npc_vld high.
- R4: A supervisor return in supervisor or machine mode copies status bit 5 into bit 1 and sets bit 5. It sets priv_mode to 2'b01 if bit 8 is 1 and to 2'b00 otherwise. It clears bit 8 and drives npc = sepc with npc_vld high.
- R5: A user return in any mode copies status bit 4 into bit 0, sets bit 4, leaves priv_mode unchanged and drives npc = uepc with npc_vld high.
- R6: A machine return outside machine mode raises illegal with npc_vld low, and leaves status and priv_mode unchanged.
- R7: A supervisor return in user mode raises illegal with npc_vld low, and leaves status and priv_mode unchanged.
- R8: An environment call raises ecall_exc with ecall_cause 8 in user mode, 9 in supervisor mode and 11 in machine mode. npc_vld and illegal stay low, and the state is unchanged.
- R9: With st_wr_en high and no strobe, status takes st_wr_data whole on the next edge. A return changes only the fields it names and keeps every other bit.
- R10: npc, npc_vld, illegal, ecall_exc and ecall_cause respond in the same cycle as the strobe. priv_mode and status change on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_onehot | input | 4 | Decoded operation strobes |
| uepc | input | 64 | User exception PC |
| sepc | input | 64 | Supervisor exception PC |
| mepc | input | 64 | Machine exception PC |
| st_wr_en | input | 1 | Whole-word status load enable |
| st_wr_data | input | 64 | Status load value |
| npc | output | 64 | Redirect target |
| npc_vld | output | 1 | Redirect valid |
| illegal | output | 1 | Illegal-instruction flag |
| ecall_exc | output | 1 | Environment-call exception flag |
| ecall_cause | output | 4 | Environment-call cause code |
| priv_mode | output | 2 | Current privilege mode |
| status | output | 64 | Current status word |

## Verification
The assertions assume that op_onehot never has more than one bit set. They also assume that a status load never arrives in the same cycle as a strobe, since the state checks would not hold against a concurrent load. The bench keeps to both rules. Each task raises exactly one strobe for one cycle, and each status load takes its own cycle with all strobes low. Every supervisor-mode case is reached by loading a saved machine previous-privilege of 2'b01 and then taking a legal machine return.

// File: rtl/priv_ret_pkg.sv
package priv_ret_pkg;

    typedef enum logic [1:0] {
        PRV_USR = 2'b00,
        PRV_SUP = 2'b01,
        PRV_MCH = 2'b11
    } prv_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_URET,
        ACT_SRET,
        ACT_MRET
    } act_e;

    localparam int OP_W     = 4;
    localparam int OP_URET  = 0;
    localparam int OP_SRET  = 1;
    localparam int OP_MRET  = 2;
    localparam int OP_ECALL = 3;

    localparam int B_UIE    = 0;
    localparam int B_SIE    = 1;
    localparam int B_MIE    = 3;
    localparam int B_UPIE   = 4;
    localparam int B_SPIE   = 5;
    localparam int B_MPIE   = 7;
    localparam int B_SPP    = 8;
    localparam int B_MPP_LO = 11;
    localparam int B_MPP_HI = 12;

    localparam int EC_CAUSE_USR = 8;
    localparam int EC_CAUSE_SUP = 9;
    localparam int EC_CAUSE_MCH = 11;

    function automatic prv_e field_to_prv(input logic [1:0] f);
        prv_e p;
        unique case (f)
            2'b01:   p = PRV_SUP;
            2'b11:   p = PRV_MCH;
            default: p = PRV_USR;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/priv_ret_check.sv
module priv_ret_check
    import priv_ret_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic [OP_W-1:0]    op,
    input  prv_e               cur_prv,
    output logic               ok_uret,
    output logic               ok_sret,
    output logic               ok_mret,
    output logic               bad,
    output logic               ec_raise,
    output logic [CAUSE_W-1:0] ec_code
);

    always_comb begin
        ok_uret  = op[OP_URET];
        ok_sret  = op[OP_SRET] && (cur_prv != PRV_USR);
        ok_mret  = op[OP_MRET] && (cur_prv == PRV_MCH);
        bad      = (op[OP_SRET] && (cur_prv == PRV_USR)) ||
                   (op[OP_MRET] && (cur_prv != PRV_MCH));
        ec_raise = op[OP_ECALL];
        unique case (cur_prv)
            PRV_USR: ec_code = CAUSE_W'(EC_CAUSE_USR);
            PRV_SUP: ec_code = CAUSE_W'(EC_CAUSE_SUP);
            default: ec_code = CAUSE_W'(EC_CAUSE_MCH);
        endcase
    end

endmodule

// File: rtl/priv_ret_update.sv
module priv_ret_update
    import priv_ret_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            ok_uret,
    input  logic            ok_sret,
    input  logic            ok_mret,
    input  logic            ld_en,
    input  logic [XLEN-1:0] ld_data,
    input  prv_e            cur_prv,
    input  logic [XLEN-1:0] cur_st,
    output prv_e            nxt_prv,
    output logic [XLEN-1:0] nxt_st
);

    act_e act;

    always_comb begin
        if (ok_mret)      act = ACT_MRET;
        else if (ok_sret) act = ACT_SRET;
        else if (ok_uret) act = ACT_URET;
        else if (ld_en)   act = ACT_LOAD;
        else              act = ACT_HOLD;
    end

    always_comb begin
        nxt_st  = cur_st;
        nxt_prv = cur_prv;
        unique case (act)
            ACT_MRET: begin
                nxt_st[B_MIE]               = cur_st[B_MPIE];
                nxt_st[B_MPIE]              = 1'b1;
                nxt_st[B_MPP_HI:B_MPP_LO]   = PRV_USR;
                nxt_prv                     = field_to_prv(cur_st[B_MPP_HI:B_MPP_LO]);
            end
            ACT_SRET: begin
                nxt_st[B_SIE]  = cur_st[B_SPIE];
                nxt_st[B_SPIE] = 1'b1;
                nxt_st[B_SPP]  = 1'b0;
                nxt_prv        = cur_st[B_SPP] ? PRV_SUP : PRV_USR;
            end
            ACT_URET: begin
                nxt_st[B_UIE]  = cur_st[B_UPIE];
                nxt_st[B_UPIE] = 1'b1;
            end
            ACT_LOAD: nxt_st = ld_data;
            default:  ;
        endcase
    end

endmodule

// File: rtl/priv_ret_unit.sv
module priv_ret_unit
    import priv_ret_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_onehot,
    input  logic [XLEN-1:0]    uepc,
    input  logic [XLEN-1:0]    sepc,
    input  logic [XLEN-1:0]    mepc,
    input  logic               st_wr_en,
    input  logic [XLEN-1:0]    st_wr_data,
    output logic [XLEN-1:0]    npc,
    output logic               npc_vld,
    output logic               illegal,
    output logic               ecall_exc,
    output logic [CAUSE_W-1:0] ecall_cause,
    output logic [1:0]         priv_mode,
    output logic [XLEN-1:0]    status
);

    prv_e            prv_q, prv_d;
    logic [XLEN-1:0] st_q, st_d;
    logic            ok_u, ok_s, ok_m;

    priv_ret_check #(.CAUSE_W(CAUSE_W)) u_check (
        .op       (op_onehot),
        .cur_prv  (prv_q),
        .ok_uret  (ok_u),
        .ok_sret  (ok_s),
        .ok_mret  (ok_m),
        .bad      (illegal),
        .ec_raise (ecall_exc),
        .ec_code  (ecall_cause)
    );

    priv_ret_update #(.XLEN(XLEN)) u_update (
        .ok_uret (ok_u),
        .ok_sret (ok_s),
        .ok_mret (ok_m),
        .ld_en   (st_wr_en),
        .ld_data (st_wr_data),
        .cur_prv (prv_q),
        .cur_st  (st_q),
        .nxt_prv (prv_d),
        .nxt_st  (st_d)
    );

    // State register: mode and status commit together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_q <= PRV_MCH;
            st_q  <= '0;
        end else begin
            prv_q <= prv_d;
            st_q  <= st_d;
        end
    end

    // Outputs
    always_comb begin
        npc_vld   = ok_u || ok_s || ok_m;
        npc       = '0;
        if (ok_m)      npc = mepc;
        else if (ok_s) npc = sepc;
        else if (ok_u) npc = uepc;
        priv_mode = prv_q;
        status    = st_q;
    end

    // Input rule for R2
    a_r2_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_onehot));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_onehot == '0) |-> (!npc_vld && !illegal && !ecall_exc));

    a_r1_mode_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        priv_mode != 2'b10);

    a_r3_mret_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (op_onehot[OP_MRET] && priv_mode == 2'b11) |=>
        (status[B_MPP_HI:B_MPP_LO] == 2'b00 && status[B_MPIE]));

    a_r4_sret_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (op_onehot[OP_SRET] && priv_mode != 2'b00) |=>
        (!status[B_SPP] && status[B_SPIE] && priv_mode != 2'b11));

    a_r6_mret_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (op_onehot[OP_MRET] && priv_mode != 2'b11 && !st_wr_en) |=>
        ($stable(status) && $stable(priv_mode)));

    a_r7_sret_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (op_onehot[OP_SRET] && priv_mode == 2'b00 && !st_wr_en) |=>
        ($stable(status) && $stable(priv_mode)));

    a_r8_ecall_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        op_onehot[OP_ECALL] |-> (!npc_vld && !illegal));

endmodule

// File: tb/priv_ret_unit_tb_top.sv
module priv_ret_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_onehot = '0;
    logic [63:0] uepc = 64'h8000_3000;
    logic [63:0] sepc = 64'h8000_2000;
    logic [63:0] mepc = 64'h8000_1000;
    logic        st_wr_en = 1'b0;
    logic [63:0] st_wr_data = '0;
    logic [63:0] npc;
    logic        npc_vld, illegal, ecall_exc;
    logic [3:0]  ecall_cause;
    logic [1:0]  priv_mode;
    logic [63:0] status;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] c_npc;
    logic        c_vld, c_ill, c_ec;
    logic [3:0]  c_cause;
    logic [1:0]  c_prv;

    always #10 clk = ~clk;

    priv_ret_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_onehot(op_onehot),
        .uepc(uepc), .sepc(sepc), .mepc(mepc),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
        .npc(npc), .npc_vld(npc_vld), .illegal(illegal),
        .ecall_exc(ecall_exc), .ecall_cause(ecall_cause),
        .priv_mode(priv_mode), .status(status)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op);
        @(negedge clk);
        op_onehot = op;
        #5;
        c_npc = npc; c_vld = npc_vld; c_ill = illegal;
        c_ec = ecall_exc; c_cause = ecall_cause; c_prv = priv_mode;
        @(negedge clk);
        op_onehot = '0;
    endtask

    task automatic load_status(input logic [63:0] v);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_data = v;
        @(negedge clk);
        st_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "priv", 64'(priv_mode), 64'd3);
        chk("R1", "status", status, 64'd0);
        chk("R1", "flags", {61'd0, npc_vld, illegal, ecall_exc}, 64'd0);
    endtask

    task automatic t_ecall(input logic [1:0] mode, input logic [3:0] cause);
        logic [63:0] s0;
        s0 = status;
        issue(4'b1000);
        chk("R8", "ecall_exc", 64'(c_ec), 64'd1);
        chk("R8", "cause", 64'(c_cause), 64'(cause));
        chk("R8", "no redirect/illegal", {62'd0, c_vld, c_ill}, 64'd0);
        chk("R8", "mode kept", 64'(priv_mode), 64'(mode));
        chk("R8", "status kept", status, s0);
    endtask

    task automatic t_uret(input logic [1:0] mode);
        logic [63:0] s0, e;
        s0 = status;
        e = s0;
        e[0] = s0[4];
        e[4] = 1'b1;
        issue(4'b0001);
        chk("R5", "npc", c_npc, uepc);
        chk("R5", "npc_vld", 64'(c_vld), 64'd1);
        chk("R5", "status", status, e);
        chk("R5", "mode kept", 64'(priv_mode), 64'(mode));
    endtask

    task automatic t_mret_legal(input logic [1:0] exp_mode);
        logic [63:0] s0, e;
        s0 = status;
        e = s0;
        e[3] = s0[7];
        e[7] = 1'b1;
        e[12:11] = 2'b00;
        issue(4'b0100);
        chk("R3", "npc", c_npc, mepc);
        chk("R3", "npc_vld/illegal", {62'd0, c_vld, c_ill}, 64'd2);
        chk("R10", "mode before edge", 64'(c_prv), 64'd3);
        chk("R3", "mode", 64'(priv_mode), 64'(exp_mode));
        chk("R9", "status fields", status, e);
    endtask

    task automatic t_sret_legal(input logic [1:0] exp_mode);
        logic [63:0] s0, e;
        s0 = status;
        e = s0;
        e[1] = s0[5];
        e[5] = 1'b1;
        e[8] = 1'b0;
        issue(4'b0010);
        chk("R4", "npc", c_npc, sepc);
        chk("R4", "npc_vld", 64'(c_vld), 64'd1);
        chk("R4", "mode", 64'(priv_mode), 64'(exp_mode));
        chk("R4", "status", status, e);
    endtask

    task automatic t_illegal(input logic [3:0] op, input string req);
        logic [63:0] s0;
        logic [1:0]  p0;
        s0 = status; p0 = priv_mode;
        issue(op);
        chk(req, "illegal", 64'(c_ill), 64'd1);
        chk(req, "npc_vld", 64'(c_vld), 64'd0);
        chk(req, "status kept", status, s0);
        chk(req, "mode kept", 64'(priv_mode), 64'(p0));
    endtask

    task automatic t_idle();
        logic [63:0] s0;
        logic [1:0]  p0;
        s0 = status; p0 = priv_mode;
        issue(4'b0000);
        chk("R2", "idle flags", {61'd0, c_vld, c_ill, c_ec}, 64'd0);
        chk("R2", "idle status", status, s0);
        chk("R2", "idle mode", 64'(priv_mode), 64'(p0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] w;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_ecall(2'b11, 4'd11);
        t_uret(2'b11);
        w = 64'h8000_0000_0000_0000 | (64'd1 << 11) | (64'd1 << 7) |
            (64'd1 << 8) | (64'd1 << 5) | (64'd1 << 4);
        load_status(w);
        chk("R9", "load", status, w);
        t_mret_legal(2'b01);
        t_ecall(2'b01, 4'd9);
        t_illegal(4'b0100, "R6");
        t_sret_legal(2'b01);
        w = (64'd1 << 1) | (64'd1 << 0);
        load_status(w);
        t_sret_legal(2'b00);
        t_ecall(2'b00, 4'd8);
        t_illegal(4'b0010, "R7");
        t_illegal(4'b0100, "R6");
        t_uret(2'b00);
        t_idle();
        do_reset();
        t_reset();
        load_status((64'd2 << 11) | (64'd1 << 3));
        t_mret_legal(2'b00);
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule